// File: doc/BRIEF.md
# Error-Correcting Parallel FIR Filter Bank

The block filters four independent sample streams with one shared 16-tap response. Alongside the four data filters it runs three redundant filters. Each redundant filter is fed the arithmetic sum of three of the data inputs. Because a FIR filter is linear, each redundant output must equal the sum of the matching data outputs. Every filter output therefore acts as one symbol of a single-error-correcting Hamming-style code. XOR is replaced by integer addition and subtraction throughout.

A decoder forms three signed check differences. A check counts as failing only when its magnitude exceeds a programmable threshold, so small quantization mismatches are ignored. The set of failing checks names one faulty filter. A faulty data filter has its output rebuilt from a failing check. A faulty redundant filter is only reported. For verification, every filter has a fault-injection input that corrupts one output sample with an XOR mask.

The decode step is a small outcome machine evaluated on every result:
- ST_CLEAN: no check fails.
- ST_DATA_FIX: two or three checks fail.
- ST_PARITY_FIX: exactly one check fails.

The failing-check pattern is the only thing that selects the outcome. Each new result moves to the outcome of its own pattern, with no memory of the previous one.

Top module: `ecc_fir_bank`

## Requirements
- R1: Tap i (i = 0..15) uses the coefficient ((13*i) mod 31) - 15. Data output k equals the sum over i of coef(i) times the sample taken i strobes earlier on stream k. Sample history is zero after reset, and inputs are 8-bit signed.
- R2: A sample accepted with `in_valid` high at clock edge n produces `out_valid` high after edge n+1, and low otherwise. `y_out`, `err_flag` and `fault_idx` change only when a new result is produced.
- R3: With no injected fault, `err_flag` is 0, `fault_idx` is 0, and every data output equals its reference value.
- R4: The three checks are defined as follows:
  - Check 1 covers data filters 1, 2 and 4.
  - Check 2 covers filters 1, 3 and 4.
  - Check 3 covers filters 2, 3 and 4.

  Each check is (sum of covered data outputs) minus (its redundant output). A check fails when its magnitude is strictly greater than `thr`. With `thr` = 0, a fault-free run flags nothing.
- R5: When a single data filter is corrupted by an error whose magnitude exceeds `thr`, `err_flag` is 1. Every data output is also restored to its reference value.
- R6: When a single redundant filter is corrupted by an error exceeding `thr`, `err_flag` is 1. The data outputs equal their raw, reference values.
- R7: An error whose magnitude is at most `thr` raises no flag, and the corrupted data output appears unchanged on `y_out`.
- R8: During and right after reset, `out_valid`, `err_flag`, `fault_idx` and `y_out` are all 0.
- R9: Bits 0..6 of `inj_sel` select filters as follows:
  - Bits 0..3 select data filters 1..4.
  - Bits 4..6 select redundant filters 1..3.

  The mask corrupts only the sample accepted in the same cycle. The following results are clean.
- R10: `fault_idx` encodes the faulty filter:
  - Values 0..3 mean data filter 1..4, selected by checks {1,2}, {1,3}, {2,3} and {1,2,3} failing respectively.
  - Values 4, 5 and 6 mean redundant filter 1, 2 and 3, each selected by its own check failing alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe for all four streams |
| x_in | input | 32 | Four signed 8-bit samples, stream k in bits 8k+7..8k |
| thr | input | 16 | Check magnitude threshold, unsigned |
| inj_sel | input | 7 | Per-filter fault-injection enable |
| inj_mask | input | 18 | XOR mask applied to selected filter outputs |
| out_valid | output | 1 | Result strobe |
| y_out | output | 72 | Four corrected signed 18-bit outputs, stream k in bits 18k+17..18k |
| err_flag | output | 1 | A filter was found faulty |
| fault_idx | output | 3 | Index of the faulty filter |

## Verification
Every result is due exactly two clock edges after the edge that accepts its sample. The filter registers load on the first edge, and the corrected output register loads on the second. The bench drives one strobe, checks that `out_valid` is still low one edge later, and reads all outputs at the falling clock after the second edge. It leaves idle cycles between samples, so no two results can overlap. For each sample, the expected corrected values, flag and index are computed arithmetically from a reference filter and the injected mask.

// File: rtl/ecc_fir_pkg.sv
package ecc_fir_pkg;

    localparam int TAPS   = 16;
    localparam int DIN_W  = 8;
    localparam int COEF_W = 8;
    localparam int DOUT_W = 18;
    localparam int NDATA  = 4;
    localparam int NPAR   = 3;
    localparam int NLANE  = NDATA + NPAR;
    localparam int PIN_W  = DIN_W + 2;
    localparam int POUT_W = PIN_W + COEF_W + $clog2(TAPS);
    localparam int SYN_W  = POUT_W + 2;
    localparam int THR_W  = 16;
    localparam int IDX_W  = 3;

    // bit k set: data stream k+1 feeds redundant filter j
    localparam logic [NDATA-1:0] CHK_MEMBERS [NPAR] = '{4'b1011, 4'b1101, 4'b1110};

    typedef enum logic [1:0] {
        ST_CLEAN,
        ST_DATA_FIX,
        ST_PARITY_FIX
    } fix_state_e;

    function automatic logic signed [COEF_W-1:0] tap_coef(input int i);
        return COEF_W'(((13 * i) % 31) - 15);
    endfunction

endpackage

// File: rtl/fir_lane.sv
module fir_lane
    import ecc_fir_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 18,
    parameter int NTAP  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [IN_W-1:0]  smp,
    input  logic                    inj,
    input  logic [OUT_W-1:0]        mask,
    output logic signed [OUT_W-1:0] y,
    output logic                    y_valid
);

    localparam int ACC_W = IN_W + COEF_W + $clog2(NTAP);

    logic signed [IN_W-1:0]  line_q [NTAP-1];
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        acc = ACC_W'(smp) * ACC_W'(tap_coef(0));
        for (int i = 1; i < NTAP; i++) begin
            acc = acc + ACC_W'(line_q[i-1]) * ACC_W'(tap_coef(i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAP - 1; i++) line_q[i] <= '0;
            y       <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= smp_valid;
            if (smp_valid) begin
                line_q[0] <= smp;
                for (int i = 1; i < NTAP - 1; i++) line_q[i] <= line_q[i-1];
                y <= OUT_W'(acc) ^ (inj ? mask : '0);
            end
        end
    end

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(y)); // R2

endmodule

// File: rtl/syndrome_decoder.sv
module syndrome_decoder
    import ecc_fir_pkg::*;
(
    input  logic signed [DOUT_W-1:0] yd   [NDATA],
    input  logic signed [POUT_W-1:0] yp   [NPAR],
    input  logic [THR_W-1:0]         thr,
    output logic signed [DOUT_W-1:0] yfix [NDATA],
    output logic                     hit,
    output logic [IDX_W-1:0]         idx
);

    logic signed [SYN_W-1:0] diff [NPAR];
    logic [SYN_W-1:0]        mag  [NPAR];
    logic [NPAR-1:0]         fail;
    fix_state_e              state;

    function automatic logic signed [DOUT_W-1:0] rebuild(
        input logic signed [DOUT_W-1:0] raw,
        input logic signed [SYN_W-1:0]  d
    );
        return DOUT_W'(SYN_W'(raw) - d);
    endfunction

    always_comb begin
        for (int j = 0; j < NPAR; j++) begin
            diff[j] = -SYN_W'(yp[j]);
            for (int k = 0; k < NDATA; k++) begin
                if (CHK_MEMBERS[j][k]) diff[j] = diff[j] + SYN_W'(yd[k]);
            end
            mag[j]  = diff[j][SYN_W-1] ? SYN_W'(-diff[j]) : SYN_W'(diff[j]);
            fail[j] = mag[j] > SYN_W'(thr);
        end
    end

    always_comb begin
        yfix  = yd;
        idx   = '0;
        state = ST_CLEAN;
        unique case (fail)
            3'b000: state = ST_CLEAN;
            3'b011: begin
                state   = ST_DATA_FIX;
                idx     = 3'd0;
                yfix[0] = rebuild(yd[0], diff[0]);
            end
            3'b101: begin
                state   = ST_DATA_FIX;
                idx     = 3'd1;
                yfix[1] = rebuild(yd[1], diff[0]);
            end
            3'b110: begin
                state   = ST_DATA_FIX;
                idx     = 3'd2;
                yfix[2] = rebuild(yd[2], diff[1]);
            end
            3'b111: begin
                state   = ST_DATA_FIX;
                idx     = 3'd3;
                yfix[3] = rebuild(yd[3], diff[0]);
            end
            3'b001: begin
                state = ST_PARITY_FIX;
                idx   = 3'd4;
            end
            3'b010: begin
                state = ST_PARITY_FIX;
                idx   = 3'd5;
            end
            3'b100: begin
                state = ST_PARITY_FIX;
                idx   = 3'd6;
            end
        endcase
        hit = (state != ST_CLEAN);
    end

endmodule

// File: rtl/ecc_fir_bank.sv
module ecc_fir_bank
    import ecc_fir_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [NDATA*DIN_W-1:0]    x_in,
    input  logic [THR_W-1:0]          thr,
    input  logic [NLANE-1:0]          inj_sel,
    input  logic [DOUT_W-1:0]         inj_mask,
    output logic                      out_valid,
    output logic [NDATA*DOUT_W-1:0]   y_out,
    output logic                      err_flag,
    output logic [IDX_W-1:0]          fault_idx
);

    logic signed [DIN_W-1:0]  xs      [NDATA];
    logic signed [PIN_W-1:0]  psum    [NPAR];
    logic signed [DOUT_W-1:0] yd      [NDATA];
    logic signed [POUT_W-1:0] yp      [NPAR];
    logic signed [DOUT_W-1:0] yfix    [NDATA];
    logic [NLANE-1:0]         lane_vld;
    logic                     fir_valid;
    logic                     hit;
    logic [IDX_W-1:0]         idx;
    logic [NDATA*DOUT_W-1:0]  raw_pk;
    logic signed [DOUT_W-1:0] y_q     [NDATA];

    assign fir_valid = &lane_vld;

    always_comb begin
        for (int j = 0; j < NPAR; j++) begin
            psum[j] = '0;
            for (int k = 0; k < NDATA; k++) begin
                if (CHK_MEMBERS[j][k]) psum[j] = psum[j] + PIN_W'(xs[k]);
            end
        end
    end

    for (genvar k = 0; k < NDATA; k++) begin : g_data
        assign xs[k] = x_in[k*DIN_W +: DIN_W];
        fir_lane #(.IN_W(DIN_W), .OUT_W(DOUT_W), .NTAP(TAPS)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_valid(in_valid),
            .smp      (xs[k]),
            .inj      (inj_sel[k]),
            .mask     (inj_mask),
            .y        (yd[k]),
            .y_valid  (lane_vld[k])
        );
        assign raw_pk[k*DOUT_W +: DOUT_W] = yd[k];
        assign y_out[k*DOUT_W +: DOUT_W]  = y_q[k];
    end

    for (genvar j = 0; j < NPAR; j++) begin : g_par
        fir_lane #(.IN_W(PIN_W), .OUT_W(POUT_W), .NTAP(TAPS)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_valid(in_valid),
            .smp      (psum[j]),
            .inj      (inj_sel[NDATA+j]),
            .mask     (POUT_W'(inj_mask)),
            .y        (yp[j]),
            .y_valid  (lane_vld[NDATA+j])
        );
    end

    syndrome_decoder u_dec (
        .yd  (yd),
        .yp  (yp),
        .thr (thr),
        .yfix(yfix),
        .hit (hit),
        .idx (idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            err_flag  <= 1'b0;
            fault_idx <= '0;
            for (int k = 0; k < NDATA; k++) y_q[k] <= '0;
        end else begin
            out_valid <= fir_valid;
            if (fir_valid) begin
                err_flag  <= hit;
                fault_idx <= idx;
                y_q       <= yfix;
            end
        end
    end

    logic signed [SYN_W-1:0] out_chk1;
    logic signed [SYN_W-1:0] out_chk2;
    assign out_chk1 = SYN_W'(y_q[0]) + SYN_W'(y_q[1]) + SYN_W'(y_q[3]);
    assign out_chk2 = SYN_W'(y_q[0]) + SYN_W'(y_q[2]) + SYN_W'(y_q[3]);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        fir_valid |=> out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fir_valid |=> ($stable(y_out) && $stable(err_flag) && $stable(fault_idx))); // R2
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_flag) |-> (fault_idx <= 3'd6)); // R10
    AST_PARITY_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_flag && fault_idx >= 3'd4) |-> (y_out == $past(raw_pk))); // R6
    AST_CHECK1_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_flag && (fault_idx == 3'd0 || fault_idx == 3'd1 || fault_idx == 3'd3))
        |-> (out_chk1 == SYN_W'($past(yp[0])))); // R5
    AST_CHECK2_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && err_flag && fault_idx == 3'd2) |-> (out_chk2 == SYN_W'($past(yp[1])))); // R5

endmodule

// File: tb/ecc_fir_bank_test.sv
module ecc_fir_bank_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] x_in;
    logic [15:0] thr;
    logic [6:0]  inj_sel;
    logic [17:0] inj_mask;
    logic        out_valid;
    logic [71:0] y_out;
    logic        err_flag;
    logic [2:0]  fault_idx;

    int  errors = 0;
    int  checks = 0;
    int  hist [4][16];
    bit  done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ecc_fir_bank uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .thr(thr),
        .inj_sel(inj_sel), .inj_mask(inj_mask), .out_valid(out_valid),
        .y_out(y_out), .err_flag(err_flag), .fault_idx(fault_idx)
    );

    function automatic int cf(input int i);
        return ((13 * i) % 31) - 15;
    endfunction

    function automatic int s18(input int v);
        logic [17:0] t;
        t = v[17:0];
        return int'($signed(t));
    endfunction

    function automatic int s22(input int v);
        logic [21:0] t;
        t = v[21:0];
        return int'($signed(t));
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one strobed sample; lane -1 means no injection; tag overrides labels
    task automatic run_sample(input int xs[4], input int lane, input int m,
                              input int t, input string tag);
        int g [4];
        int gp [3];
        int outs [4];
        int e;
        int rawv;
        bit err_e;
        int idx_e;
        string tf;
        string tx;
        for (int k = 0; k < 4; k++) begin
            for (int i = 15; i > 0; i--) hist[k][i] = hist[k][i-1];
            hist[k][0] = xs[k];
            g[k] = 0;
            for (int i = 0; i < 16; i++) g[k] += cf(i) * hist[k][i];
            outs[k] = g[k];
        end
        gp[0] = g[0] + g[1] + g[3];
        gp[1] = g[0] + g[2] + g[3];
        gp[2] = g[1] + g[2] + g[3];
        err_e = 0;
        idx_e = 0;
        tf = "R1";
        tx = "R3";
        if (lane >= 0 && lane < 4) begin
            rawv = s18(g[lane] ^ m);
            e = rawv - g[lane];
            if (iabs(e) > t) begin
                err_e = 1; idx_e = lane; tf = "R5"; tx = "R10";
            end else begin
                outs[lane] = rawv; tf = "R7"; tx = "R7";
            end
        end else if (lane >= 4) begin
            rawv = s22(gp[lane-4] ^ m);
            e = rawv - gp[lane-4];
            tf = "R6";
            if (iabs(e) > t) begin
                err_e = 1; idx_e = lane; tx = "R10";
            end else begin
                tx = "R7";
            end
        end
        if (tag != "") begin
            tf = tag; tx = tag;
        end
        @(negedge clk);
        in_valid = 1'b1;
        for (int k = 0; k < 4; k++) x_in[k*8 +: 8] = xs[k][7:0];
        thr      = t[15:0];
        inj_sel  = (lane >= 0) ? 7'(1 << lane) : 7'd0;
        inj_mask = m[17:0];
        @(negedge clk);
        in_valid = 1'b0;
        inj_sel  = 7'd0;
        chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2", int'(out_valid), 1);
        chk(err_flag == err_e, tx, int'(err_flag), int'(err_e));
        chk(int'(fault_idx) == idx_e, tx, int'(fault_idx), idx_e);
        for (int k = 0; k < 4; k++) begin
            chk(int'($signed(y_out[k*18 +: 18])) == outs[k], tf,
                int'($signed(y_out[k*18 +: 18])), outs[k]);
        end
    endtask

    task automatic rand_xs(output int xs[4]);
        for (int k = 0; k < 4; k++) xs[k] = int'($urandom_range(255)) - 128;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int xs [4];
        int masks [8];
        masks = '{1, 2, 4, 16, 1024, 32'h20000, 32'h3FFFF, 32'h155};
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 16; i++) hist[k][i] = 0;
        rst_n = 1'b0; in_valid = 1'b0; x_in = '0; thr = 16'd4;
        inj_sel = '0; inj_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && err_flag == 1'b0 && fault_idx == 3'd0, "R8",
            int'({out_valid, err_flag, fault_idx}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && y_out == '0, "R8", int'(out_valid), 0);

        // extremes, fault free
        for (int s = 0; s < 20; s++) begin
            xs = '{-128, -128, -128, -128};
            run_sample(xs, -1, 0, 4, "");
        end
        for (int s = 0; s < 20; s++) begin
            xs = '{127, 127, 127, 127};
            run_sample(xs, -1, 0, 4, "");
        end
        for (int s = 0; s < 20; s++) begin
            xs = (s % 2 == 0) ? '{127, -128, 127, -128} : '{-128, 127, -128, 127};
            run_sample(xs, -1, 0, 4, "");
        end

        // every lane, every mask; fault only on second sample
        for (int lane = -1; lane < 7; lane++) begin
            for (int mi = 0; mi < 8; mi++) begin
                for (int s = 0; s < 4; s++) begin
                    rand_xs(xs);
                    if (s == 1)      run_sample(xs, lane, masks[mi], 4, "");
                    else if (s > 1)  run_sample(xs, -1, 0, 4, "R9");
                    else             run_sample(xs, -1, 0, 4, "");
                end
            end
        end

        // threshold edge: bit 3 flip gives an error of magnitude 8 (R4)
        rand_xs(xs);
        run_sample(xs, 0, 8, 7, "R4");
        rand_xs(xs);
        run_sample(xs, 0, 8, 8, "R4");
        rand_xs(xs);
        run_sample(xs, 5, 8, 7, "R4");
        rand_xs(xs);
        run_sample(xs, 5, 8, 8, "R4");
        // zero threshold, no fault: exact arithmetic flags nothing (R4)
        for (int s = 0; s < 8; s++) begin
            rand_xs(xs);
            run_sample(xs, -1, 0, 0, "R4");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule